// File: doc/BRIEF.md
# I/O Trap Capture and Restart Unit

This unit covers the I/O-instruction part of system-management interrupt handling. When the management-interrupt entry strobe arrives, it records whether the interrupted point was the boundary of an I/O instruction. If it was, the unit also records the port number and the transfer direction in a read-only trap status word. At the same moment it stores the pointer of the trapped instruction and the pointer of the instruction that follows it, and it clears a 16-bit restart slot.

While the handler runs, software reads both words through a small register port. It writes the restart slot to ask for the trapped access to be replayed. A typical use is a write to a device that was powered down and has since been brought back up.

When the resume strobe arrives, the unit registers the pointer at which execution continues. Writing the re-execute code 00FFh to the restart slot selects the trapped instruction again. Any other code selects the next instruction. The unit has two named states: RUN (normal execution) and HANDLER (inside the management handler). The transition ENTER goes from RUN to HANDLER on the entry strobe. The transition RESUME goes from HANDLER back to RUN on the resume strobe.

Top module: `io_trap_unit`

## Requirements
- R1: The trap status word reads at register offset FFA4h. Its bits 31:16 hold the port number, bit 1 holds the valid flag, and bit 0 holds the direction (1 = input, 0 = output). Bits 15:2 always read 0.
- R2: On ENTER with the I/O-boundary input at 1, the unit sets the valid flag and captures the port and direction. On ENTER with that input at 0, the valid flag is 0 and the port and direction fields read 0.
- R3: The restart slot reads at offset FF00h as {16'h0000, code}. Every ENTER clears the code to 0000h.
- R4: A write to FF00h in HANDLER stores wdata[15:0] as the code. Bits 31:16 of the write are ignored.
- R5: Writes to FF00h in RUN, whether before an entry or after a resume, leave the code unchanged.
- R6: Writes to FFA4h have no effect on the trap status word.
- R7: On RESUME with the valid flag at 1 and the code equal to 00FFh, resume_ip becomes the captured trapped-instruction pointer.
- R8: On RESUME with any code other than 00FFh (0000h included), resume_ip becomes the captured next-instruction pointer.
- R9: On RESUME with the valid flag at 0, resume_ip becomes the captured next-instruction pointer, whatever the code is.
- R10: resume_ip changes only at the clock edge that samples the resume strobe in HANDLER. It is readable after that edge and holds at all other times. A resume strobe in RUN is ignored.
- R11: An entry strobe in HANDLER is ignored. It causes no recapture and does not clear the restart slot.
- R12: A read of any offset other than FFA4h or FF00h returns 0.
- R13: After reset the unit is in RUN, both words read 0, and resume_ip is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_enter | input | 1 | Management-interrupt entry strobe |
| io_boundary | input | 1 | 1 when the interrupted point is an I/O instruction boundary |
| io_port | input | PORT_W | Port number of the I/O instruction |
| io_is_in | input | 1 | 1 = input instruction, 0 = output instruction |
| ip_trapped | input | IP_W | Pointer of the interrupted I/O instruction |
| ip_next | input | IP_W | Pointer of the following instruction |
| reg_addr | input | 16 | Register offset for reads and writes |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| resume | input | 1 | Resume strobe |
| resume_ip | output | IP_W | Registered resume pointer |

## Verification
The bench builds the unit with PORT_W = 16 and IP_W = 20. With that pointer width, the bench can derive distinct trapped and next pointers arithmetically from the episode index, and a wrong selection can never alias the right one. The sweep crosses the valid flag and the direction with seven restart codes: 0000h, 00FFh, near misses that differ from 00FFh in one bit or in the upper byte, and FFFFh. For each combination it runs a full ENTER, handler and RESUME episode. It also probes stray entry strobes, status-word writes and late slot writes inside that episode.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
    localparam int REG_AW = 16;
    localparam int REG_DW = 32;
    localparam int CODE_W = 16;

    localparam logic [REG_AW-1:0] OFS_STATUS  = 16'hFFA4;
    localparam logic [REG_AW-1:0] OFS_RESTART = 16'hFF00;
    localparam logic [CODE_W-1:0] CODE_REEXEC = 16'h00FF;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_HANDLER = 1'b1
    } trap_state_e;
endpackage

// File: rtl/io_trap_fsm.sv
module io_trap_fsm
    import io_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smi_enter,
    input  logic        resume,
    output trap_state_e state_q,
    output logic        enter_go,
    output logic        resume_go
);
    trap_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        enter_go  = 1'b0;
        resume_go = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (smi_enter) begin
                    enter_go = 1'b1;
                    state_d  = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (resume) begin
                    resume_go = 1'b1;
                    state_d   = ST_RUN;
                end
            end
        endcase
    end
endmodule

// File: rtl/io_trap_capture.sv
module io_trap_capture
    import io_trap_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int IP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_go,
    input  logic              io_boundary,
    input  logic [PORT_W-1:0] io_port,
    input  logic              io_is_in,
    input  logic [IP_W-1:0]   ip_trapped,
    input  logic [IP_W-1:0]   ip_next,
    output logic [REG_DW-1:0] status_word,
    output logic              trap_valid,
    output logic [IP_W-1:0]   trap_ip,
    output logic [IP_W-1:0]   next_ip
);
    localparam int PAD_W = REG_DW - PORT_W - 2;

    logic [PORT_W-1:0] port_q;
    logic              dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q     <= '0;
            dir_q      <= 1'b0;
            trap_valid <= 1'b0;
            trap_ip    <= '0;
            next_ip    <= '0;
        end else if (enter_go) begin
            trap_valid <= io_boundary;
            port_q     <= io_boundary ? io_port : '0;
            dir_q      <= io_boundary & io_is_in;
            trap_ip    <= ip_trapped;
            next_ip    <= ip_next;
        end
    end

    assign status_word = {port_q, {PAD_W{1'b0}}, trap_valid, dir_q};
endmodule

// File: rtl/io_trap_restart.sv
module io_trap_restart
    import io_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_go,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_q,
    output logic              reexec
);
    always_ff @(posedge clk) begin
        if (!rst_n)        code_q <= '0;
        else if (enter_go) code_q <= '0;
        else if (wr_en)    code_q <= wr_code;
    end

    assign reexec = (code_q == CODE_REEXEC);
endmodule

// File: rtl/io_trap_unit.sv
module io_trap_unit
    import io_trap_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int IP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_enter,
    input  logic              io_boundary,
    input  logic [PORT_W-1:0] io_port,
    input  logic              io_is_in,
    input  logic [IP_W-1:0]   ip_trapped,
    input  logic [IP_W-1:0]   ip_next,
    input  logic [15:0]       reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              resume,
    output logic [IP_W-1:0]   resume_ip
);
    trap_state_e       state_q;
    logic              enter_go;
    logic              resume_go;
    logic [REG_DW-1:0] status_word;
    logic              trap_valid;
    logic [IP_W-1:0]   trap_ip;
    logic [IP_W-1:0]   next_ip;
    logic [CODE_W-1:0] code_q;
    logic              reexec;
    logic              slot_wr;

    io_trap_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smi_enter (smi_enter),
        .resume    (resume),
        .state_q   (state_q),
        .enter_go  (enter_go),
        .resume_go (resume_go)
    );

    io_trap_capture #(.PORT_W(PORT_W), .IP_W(IP_W)) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_go    (enter_go),
        .io_boundary (io_boundary),
        .io_port     (io_port),
        .io_is_in    (io_is_in),
        .ip_trapped  (ip_trapped),
        .ip_next     (ip_next),
        .status_word (status_word),
        .trap_valid  (trap_valid),
        .trap_ip     (trap_ip),
        .next_ip     (next_ip)
    );

    assign slot_wr = reg_we && (reg_addr == OFS_RESTART) && (state_q == ST_HANDLER);

    io_trap_restart i_restart (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_go (enter_go),
        .wr_en    (slot_wr),
        .wr_code  (reg_wdata[CODE_W-1:0]),
        .code_q   (code_q),
        .reexec   (reexec)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_STATUS:  reg_rdata = status_word;
            OFS_RESTART: reg_rdata = {{(REG_DW-CODE_W){1'b0}}, code_q};
            default:     reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         resume_ip <= '0;
        else if (resume_go) resume_ip <= (trap_valid && reexec) ? trap_ip : next_ip;
    end
endmodule

// File: rtl/io_trap_chk.sv
module io_trap_chk
    import io_trap_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int IP_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input trap_state_e       state_q,
    input logic              enter_go,
    input logic              resume_go,
    input logic [REG_DW-1:0] status_word,
    input logic              trap_valid,
    input logic              reexec,
    input logic [IP_W-1:0]   trap_ip,
    input logic [IP_W-1:0]   next_ip,
    input logic [CODE_W-1:0] code_q,
    input logic [IP_W-1:0]   resume_ip
);
    AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[REG_DW-PORT_W-1:2] == '0); // R1

    AST_INVALID_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[1] |-> (status_word[REG_DW-1:REG_DW-PORT_W] == '0 && !status_word[0])); // R2

    AST_ENTRY_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enter_go) |-> code_q == '0); // R3

    AST_SLOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && !$past(enter_go)) |-> $stable(code_q)); // R5

    AST_RESUME_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(resume_go) |-> resume_ip == ($past(trap_valid && reexec) ? $past(trap_ip) : $past(next_ip))); // R7

    AST_INVALID_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(resume_go && !trap_valid) |-> resume_ip == $past(next_ip)); // R9

    AST_RESUME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(resume_go) |-> $stable(resume_ip)); // R10

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HANDLER && $past(state_q) == ST_HANDLER) |-> $stable(status_word)); // R11
endmodule

bind io_trap_unit io_trap_chk #(.PORT_W(PORT_W), .IP_W(IP_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .enter_go    (enter_go),
    .resume_go   (resume_go),
    .status_word (status_word),
    .trap_valid  (trap_valid),
    .reexec      (reexec),
    .trap_ip     (trap_ip),
    .next_ip     (next_ip),
    .code_q      (code_q),
    .resume_ip   (resume_ip)
);

// File: tb/test_io_trap_unit.sv
module test_io_trap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PORT_W = 16;
    localparam int IP_W   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smi_enter = 1'b0;
    logic              io_boundary = 1'b0;
    logic [PORT_W-1:0] io_port = '0;
    logic              io_is_in = 1'b0;
    logic [IP_W-1:0]   ip_trapped = '0;
    logic [IP_W-1:0]   ip_next = '0;
    logic [15:0]       reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              resume = 1'b0;
    logic [IP_W-1:0]   resume_ip;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_trap_unit #(.PORT_W(PORT_W), .IP_W(IP_W)) i_io_trap_unit (
        .clk(clk), .rst_n(rst_n), .smi_enter(smi_enter), .io_boundary(io_boundary),
        .io_port(io_port), .io_is_in(io_is_in), .ip_trapped(ip_trapped), .ip_next(ip_next),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .resume(resume), .resume_ip(resume_ip)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] pad_ip(input logic [IP_W-1:0] v);
        return {{(32-IP_W){1'b0}}, v};
    endfunction

    logic [15:0] codes [7];

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        codes[0] = 16'h0000; codes[1] = 16'h00FF; codes[2] = 16'h00FE; codes[3] = 16'h01FF;
        codes[4] = 16'hFFFF; codes[5] = 16'h0001; codes[6] = 16'h80FF;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R13 reset state
        read_chk("R13", 16'hFFA4, 32'h0);
        read_chk("R13", 16'hFF00, 32'h0);
        check("R13", pad_ip(resume_ip), 32'h0);
        // R5 write before any entry
        wr(16'hFF00, 32'h0000_00FF);
        read_chk("R5", 16'hFF00, 32'h0);
        // R10 resume in RUN ignored
        resume = 1'b1; tick(); resume = 1'b0;
        check("R10", pad_ip(resume_ip), 32'h0);
        // R12 unmapped
        read_chk("R12", 16'h1234, 32'h0);
        read_chk("R12", 16'hFFA0, 32'h0);

        for (int e = 0; e < 28; e++) begin
            logic              v;
            logic              d;
            logic [15:0]       code;
            logic [PORT_W-1:0] p;
            logic [IP_W-1:0]   t;
            logic [IP_W-1:0]   n;
            logic [31:0]       exp_stat;
            logic [IP_W-1:0]   exp_ip;
            logic [IP_W-1:0]   prev_ip;
            v    = e[0];
            d    = e[1];
            code = codes[e / 4];
            p    = PORT_W'(16'h0100 * e + 16'h0033 + e);
            t    = IP_W'(32'h1000 + e * 32'h111);
            n    = t + IP_W'(2 + (e % 3));
            exp_stat = {v ? p : 16'h0, 14'h0, v, v & d};
            exp_ip   = (v && code == 16'h00FF) ? t : n;

            // ENTER
            io_boundary = v; io_port = p; io_is_in = d; ip_trapped = t; ip_next = n;
            smi_enter = 1'b1; tick(); smi_enter = 1'b0;
            read_chk("R1", 16'hFFA4, exp_stat);   // R1 and R2 layout/capture
            read_chk("R3", 16'hFF00, 32'h0);      // cleared on entry
            // R4 write with upper junk
            wr(16'hFF00, {16'hA5C3, code});
            read_chk("R4", 16'hFF00, {16'h0, code});
            // R6 status write ignored
            wr(16'hFFA4, 32'hFFFF_FFFF);
            read_chk("R6", 16'hFFA4, exp_stat);
            // R11 stray entry
            io_boundary = ~v; io_port = ~p; io_is_in = ~d; ip_trapped = ~t; ip_next = ~n;
            smi_enter = 1'b1; tick(); smi_enter = 1'b0;
            read_chk("R11", 16'hFFA4, exp_stat);
            read_chk("R11", 16'hFF00, {16'h0, code});
            // RESUME
            prev_ip = resume_ip;
            resume = 1'b1;
            #1;
            check("R10", pad_ip(resume_ip), pad_ip(prev_ip));
            tick(); resume = 1'b0;
            if (!v)                    check("R9", pad_ip(resume_ip), pad_ip(exp_ip));
            else if (code == 16'h00FF) check("R7", pad_ip(resume_ip), pad_ip(exp_ip));
            else                       check("R8", pad_ip(resume_ip), pad_ip(exp_ip));
            // R5 late write, R10 hold
            wr(16'hFF00, 32'h0000_1234);
            read_chk("R5", 16'hFF00, {16'h0, code});
            resume = 1'b1; tick(); resume = 1'b0;
            check("R10", pad_ip(resume_ip), pad_ip(exp_ip));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule